// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This block sits beside the Compute stage of a five-stage in-order pipeline. For each of the two ALU inputs, it decides where the operand should come from:

- the value read from the register file during Decode;
- the result waiting in the buffer between Compute and Memory (RZ), which holds the result of the instruction directly ahead;
- the value waiting in the buffer after Memory (RY), which holds the result of the instruction two places ahead.

It drives the two multiplexer selects and also returns the chosen operand values, so the ALU can use them directly.

A forwarded value is only useful if it exists when it is needed. A load that sits in the Memory stage has not yet fetched its data. If the instruction in Compute needs that load's result, the unit raises a stall for one cycle. During that cycle the pipeline holds the instruction in Compute and inserts a bubble into Memory. On the next cycle the load has moved to the buffer after Memory, and its data is forwarded from RY.

Register 0 is never forwarded. A producer whose write enable is low is never forwarded. A small piece of state makes sure one hazard never produces more than a single stall cycle.

Top module: `fwd_unit`

## Requirements
- R1: When neither older producer writes a register named by a source, that source's select is 2'b00 and its operand equals the register-file value.
- R2: When the Memory-stage producer is not a load, has its write enable set, and names a nonzero destination equal to a source, that source's select is 2'b01 and its operand equals the RZ value.
- R3: When only the producer after Memory (write enable set, nonzero destination) matches a source, that source's select is 2'b10 and its operand equals the RY value.
- R4: When both producers match the same source, the Memory-stage producer wins: the select is 2'b01.
- R5: A producer whose destination is register 0, or whose write enable is low, never changes a select and never causes a stall.
- R6: The two sources are resolved independently. One may forward while the other does not, or each may forward from a different stage.
- R7: A Memory-stage load with its write enable set, a nonzero destination and a matching source raises the stall output in the same cycle. That source then never selects 2'b01: it falls back to 2'b10 if the producer after Memory matches, and to 2'b00 otherwise.
- R8: The stall output is never high on two consecutive cycles. Its timing follows a register that resets to "not stalled":
  - a hazard present on the first cycle after reset stalls;
  - if the hazard inputs are held unchanged, the stall output alternates high and low.
- R9: The select value 2'b11 never appears on either select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_src_a | input | ADDR_W | First source register of the instruction in Compute |
| ex_src_b | input | ADDR_W | Second source register of the instruction in Compute |
| rf_opnd_a | input | DATA_W | Register-file value for the first source |
| rf_opnd_b | input | DATA_W | Register-file value for the second source |
| mem_dst | input | ADDR_W | Destination of the instruction in Memory |
| mem_wen | input | 1 | Write enable of the instruction in Memory |
| mem_is_load | input | 1 | The instruction in Memory is a load |
| mem_rz | input | DATA_W | Result held in the Compute/Memory buffer |
| wb_dst | input | ADDR_W | Destination of the instruction after Memory |
| wb_wen | input | 1 | Write enable of the instruction after Memory |
| wb_ry | input | DATA_W | Value held in the buffer after Memory |
| sel_a | output | 2 | Select for the first ALU input |
| sel_b | output | 2 | Select for the second ALU input |
| alu_opnd_a | output | DATA_W | Chosen first operand |
| alu_opnd_b | output | DATA_W | Chosen second operand |
| stall | output | 1 | One-cycle load-use stall request |

## Verification
The bench drives the unit with the following producer and consumer patterns:

- no dependency;
- a match in Memory only;
- a match after Memory only;
- a match in both stages;
- the same register used by both sources;
- different stages feeding each source.

Together these show whether the priority and the per-source independence are right. Register-0 and write-disabled producers are placed so that a wrongly forwarded value would show up on the operand outputs. Load producers are tried with and without a matching producer behind them, which separates the RY fallback from the register-file fallback. A held hazard shows whether the stall releases after exactly one cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF = 2'b00,
        SEL_RZ = 2'b01,
        SEL_RY = 2'b10
    } fwd_sel_e;

    // Priority: the younger producer in Memory first, unless it is a load
    function automatic fwd_sel_e pick_source(input logic hit_mem,
                                             input logic mem_load,
                                             input logic hit_wb);
        if (hit_mem && !mem_load) return SEL_RZ;
        if (hit_wb)               return SEL_RY;
        return SEL_RF;
    endfunction

endpackage

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] mem_dst,
    input  logic              mem_wen,
    input  logic              mem_is_load,
    input  logic [ADDR_W-1:0] wb_dst,
    input  logic              wb_wen,
    output fwd_sel_e          sel,
    output logic              load_hazard
);
    localparam logic [ADDR_W-1:0] ZERO_REG = '0;

    logic hit_mem;
    logic hit_wb;

    always_comb begin
        hit_mem     = mem_wen && (mem_dst != ZERO_REG) && (mem_dst == src);
        hit_wb      = wb_wen  && (wb_dst  != ZERO_REG) && (wb_dst  == src);
        load_hazard = hit_mem && mem_is_load;
        sel         = pick_source(hit_mem, mem_is_load, hit_wb);
    end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] rz_val,
    input  logic [DATA_W-1:0] ry_val,
    output logic [DATA_W-1:0] out_val
);
    always_comb begin
        unique case (sel)
            SEL_RZ:  out_val = rz_val;
            SEL_RY:  out_val = ry_val;
            default: out_val = rf_val;
        endcase
    end
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock (
    input  logic clk,
    input  logic rst,
    input  logic hazard,
    output logic stall
);
    logic stalled_q;

    // Grant at most one stall cycle per hazard
    assign stall = hazard && !stalled_q;

    always_ff @(posedge clk) begin
        if (rst) stalled_q <= 1'b0;
        else     stalled_q <= stall;
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ex_src_a,
    input  logic [ADDR_W-1:0] ex_src_b,
    input  logic [DATA_W-1:0] rf_opnd_a,
    input  logic [DATA_W-1:0] rf_opnd_b,
    input  logic [ADDR_W-1:0] mem_dst,
    input  logic              mem_wen,
    input  logic              mem_is_load,
    input  logic [DATA_W-1:0] mem_rz,
    input  logic [ADDR_W-1:0] wb_dst,
    input  logic              wb_wen,
    input  logic [DATA_W-1:0] wb_ry,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] alu_opnd_a,
    output logic [DATA_W-1:0] alu_opnd_b,
    output logic              stall
);
    localparam int NUM_SRC = 2;

    logic [ADDR_W-1:0] src_vec [NUM_SRC];
    logic [DATA_W-1:0] rf_vec  [NUM_SRC];
    logic [DATA_W-1:0] out_vec [NUM_SRC];
    fwd_sel_e          sel_vec [NUM_SRC];
    logic [NUM_SRC-1:0] hazard_vec;

    assign src_vec[0] = ex_src_a;
    assign src_vec[1] = ex_src_b;
    assign rf_vec[0]  = rf_opnd_a;
    assign rf_vec[1]  = rf_opnd_b;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        fwd_select #(.ADDR_W(ADDR_W)) u_select (
            .src         (src_vec[i]),
            .mem_dst     (mem_dst),
            .mem_wen     (mem_wen),
            .mem_is_load (mem_is_load),
            .wb_dst      (wb_dst),
            .wb_wen      (wb_wen),
            .sel         (sel_vec[i]),
            .load_hazard (hazard_vec[i])
        );

        fwd_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_vec[i]),
            .rf_val  (rf_vec[i]),
            .rz_val  (mem_rz),
            .ry_val  (wb_ry),
            .out_val (out_vec[i])
        );
    end

    load_use_interlock u_interlock (
        .clk    (clk),
        .rst    (rst),
        .hazard (|hazard_vec),
        .stall  (stall)
    );

    assign sel_a      = sel_vec[0];
    assign sel_b      = sel_vec[1];
    assign alu_opnd_a = out_vec[0];
    assign alu_opnd_b = out_vec[1];
endmodule

// File: rtl/fwd_unit_checker.sv
module fwd_unit_checker #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] ex_src_a,
    input logic [ADDR_W-1:0] ex_src_b,
    input logic [DATA_W-1:0] rf_opnd_a,
    input logic [DATA_W-1:0] rf_opnd_b,
    input logic [ADDR_W-1:0] mem_dst,
    input logic              mem_wen,
    input logic              mem_is_load,
    input logic [DATA_W-1:0] mem_rz,
    input logic [ADDR_W-1:0] wb_dst,
    input logic              wb_wen,
    input logic [DATA_W-1:0] wb_ry,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] alu_opnd_a,
    input logic [DATA_W-1:0] alu_opnd_b,
    input logic              stall
);
    logic mem_live, wb_live, mem_hit_a, mem_hit_b, wb_hit_a, load_use;

    assign mem_live  = mem_wen && (mem_dst != '0);
    assign wb_live   = wb_wen && (wb_dst != '0);
    assign mem_hit_a = mem_live && (mem_dst == ex_src_a);
    assign mem_hit_b = mem_live && (mem_dst == ex_src_b);
    assign wb_hit_a  = wb_live && (wb_dst == ex_src_a);
    assign load_use  = mem_is_load && (mem_hit_a || mem_hit_b);

    assert_no_match_R1: assert property (@(posedge clk) disable iff (rst)
        (!mem_hit_a && !wb_hit_a) |-> (sel_a == 2'b00 && alu_opnd_a == rf_opnd_a));

    assert_mem_forward_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_hit_a && !mem_is_load) |-> (sel_a == 2'b01 && alu_opnd_a == mem_rz));

    assert_wb_forward_R3: assert property (@(posedge clk) disable iff (rst)
        (!mem_hit_a && wb_hit_a) |-> (sel_a == 2'b10 && alu_opnd_a == wb_ry));

    assert_younger_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_hit_b && !mem_is_load && wb_live && wb_dst == ex_src_b) |-> (sel_b == 2'b01));

    assert_dead_producer_R5: assert property (@(posedge clk) disable iff (rst)
        (!mem_live && !wb_live) |-> (sel_a == 2'b00 && sel_b == 2'b00 && !stall));

    assert_load_use_R7: assert property (@(posedge clk) disable iff (rst)
        load_use |-> ((stall || $past(stall)) && sel_a != 2'b01 && sel_b != 2'b01));

    assert_single_stall_R8: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    assert_legal_select_R9: assert property (@(posedge clk) disable iff (rst)
        (sel_a != 2'b11 && sel_b != 2'b11));
endmodule

bind fwd_unit fwd_unit_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd_chk (.*);

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
    localparam int AW = 5;
    localparam int DW = 32;
    localparam logic [DW-1:0] RF_A = 32'h0000_1111;
    localparam logic [DW-1:0] RF_B = 32'h0000_2222;
    localparam logic [DW-1:0] RZ_V = 32'h0000_3333;
    localparam logic [DW-1:0] RY_V = 32'h0000_4444;

    typedef struct packed {
        logic [3:0]    req;
        logic [AW-1:0] sa;
        logic [AW-1:0] sb;
        logic [AW-1:0] md;
        logic          mw;
        logic          ml;
        logic [AW-1:0] wd;
        logic          ww;
        logic [1:0]    ea;
        logic [1:0]    eb;
        logic          es;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{4'd1, 5'd3,  5'd4,  5'd7,  1'b1, 1'b0, 5'd8,  1'b1, 2'b00, 2'b00, 1'b0}, // R1
        '{4'd2, 5'd3,  5'd4,  5'd3,  1'b1, 1'b0, 5'd9,  1'b1, 2'b01, 2'b00, 1'b0}, // R2
        '{4'd6, 5'd5,  5'd3,  5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 2'b00, 2'b01, 1'b0}, // R6
        '{4'd3, 5'd6,  5'd7,  5'd1,  1'b1, 1'b0, 5'd6,  1'b1, 2'b10, 2'b00, 1'b0}, // R3
        '{4'd4, 5'd2,  5'd2,  5'd2,  1'b1, 1'b0, 5'd2,  1'b1, 2'b01, 2'b01, 1'b0}, // R4
        '{4'd5, 5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 2'b00, 2'b00, 1'b0}, // R5
        '{4'd5, 5'd4,  5'd5,  5'd4,  1'b0, 1'b0, 5'd5,  1'b0, 2'b00, 2'b00, 1'b0}, // R5
        '{4'd7, 5'd9,  5'd10, 5'd9,  1'b1, 1'b1, 5'd0,  1'b0, 2'b00, 2'b00, 1'b1}, // R7
        '{4'd1, 5'd1,  5'd2,  5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 2'b00, 2'b00, 1'b0}, // R1
        '{4'd7, 5'd9,  5'd11, 5'd9,  1'b1, 1'b1, 5'd9,  1'b1, 2'b10, 2'b00, 1'b1}, // R7
        '{4'd6, 5'd12, 5'd13, 5'd12, 1'b1, 1'b0, 5'd13, 1'b1, 2'b01, 2'b10, 1'b0}, // R6
        '{4'd5, 5'd8,  5'd8,  5'd8,  1'b0, 1'b1, 5'd8,  1'b1, 2'b10, 2'b10, 1'b0}, // R5
        '{4'd5, 5'd0,  5'd14, 5'd0,  1'b1, 1'b1, 5'd14, 1'b1, 2'b00, 2'b10, 1'b0}  // R5
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] ex_src_a = '0, ex_src_b = '0, mem_dst = '0, wb_dst = '0;
    logic mem_wen = 1'b0, mem_is_load = 1'b0, wb_wen = 1'b0;
    logic [DW-1:0] rf_opnd_a = RF_A, rf_opnd_b = RF_B, mem_rz = RZ_V, wb_ry = RY_V;
    logic [1:0] sel_a, sel_b;
    logic [DW-1:0] alu_opnd_a, alu_opnd_b;
    logic stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fwd_unit #(.ADDR_W(AW), .DATA_W(DW)) u_fwd_unit (.*);

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf);
        case (s)
            2'b01:   return RZ_V;
            2'b10:   return RY_V;
            default: return rf;
        endcase
    endfunction

    task automatic drive(input vec_t v);
        ex_src_a = v.sa; ex_src_b = v.sb;
        mem_dst = v.md; mem_wen = v.mw; mem_is_load = v.ml;
        wb_dst = v.wd; wb_wen = v.ww;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: hazard present on the first cycle after reset stalls at once
        drive(VEC[7]);
        #1 check("R8 stall after reset", 32'(stall), 32'd1);
        // R8: hold the hazard; stall alternates high and low
        @(negedge clk); #1 check("R8 held hazard released", 32'(stall), 32'd0);
        @(negedge clk); #1 check("R8 held hazard re-stalls", 32'(stall), 32'd1);
        @(negedge clk);
        drive(VEC[0]);
        @(negedge clk);

        // Vector table: R1..R7, R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #1;
            tag = $sformatf("R%0d vec %0d", VEC[i].req, i);
            check({tag, " sel_a"}, 32'(sel_a), 32'(VEC[i].ea));
            check({tag, " sel_b"}, 32'(sel_b), 32'(VEC[i].eb));
            check({tag, " opnd_a"}, alu_opnd_a, pick(VEC[i].ea, RF_A));
            check({tag, " opnd_b"}, alu_opnd_b, pick(VEC[i].eb, RF_B));
            check({tag, " stall"}, 32'(stall), 32'(VEC[i].es));
            // R9: the unused encoding never shows
            check({tag, " R9 legal"}, 32'(sel_a == 2'b11 || sel_b == 2'b11), 32'd0);
        end

        // R7: load hitting source b only, nothing behind it -> register file
        @(negedge clk);
        drive('{4'd7, 5'd1, 5'd6, 5'd6, 1'b1, 1'b1, 5'd2, 1'b1, 2'b00, 2'b00, 1'b1});
        #1;
        check("R7 load on b stall", 32'(stall), 32'd1);
        check("R7 load on b sel_b", 32'(sel_b), 32'd0);
        check("R7 load on b opnd_b", alu_opnd_b, RF_B);

        // Reset state: with reset held, a clean pattern gives register-file operands
        @(negedge clk);
        rst = 1'b1;
        drive(VEC[0]);
        #1;
        check("R1 reset sel_a", 32'(sel_a), 32'd0);
        check("R1 reset opnd_b", alu_opnd_b, RF_B);
        check("R8 reset no stall", 32'(stall), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule